// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This unit collects level-sensitive interrupt lines from up to 64 vector sources and from a 16-line legacy peripheral bus, and presents at most one vector interrupt to the processor core at a time. Five of the legacy lines are translated to fixed vector numbers and merged with the direct vector lines. All other legacy lines are dropped without any effect.

A rising edge on any merged line while the unit is idle captures that source. The unit sets a busy flag, raises the interrupt request, drives the dedicated vector trap code and loads three data words. The first word carries a fixed five-bit tag above the source number. The other two words are zero. While busy, further rising edges are ignored and not queued. The delivery ends when the owning source drops its line or when the core pulses the clear input.

Top module: `ivec_dispatch`

## Requirements
- R1: After reset, status_o, irq_o, trap_o and all three data words are zero.
- R2: A rising edge on a merged source line while idle sets status_o to 8'h20 (busy at bit 5) and raises irq_o on the next clock edge.
- R3: On delivery, data0_o becomes (5'h1F << 6) | source number (e.g. source 5 gives 11'h7C5, source 63 gives 11'h7FF), and data1_o and data2_o are zero.
- R4: trap_o is 9'h060 while irq_o is high and 9'h000 while idle.
- R5: A rising edge while busy is ignored: data0_o keeps the captured source, and the edge is not replayed after the busy flag clears.
- R6: When the owning source line goes low while busy, busy and irq_o clear on the next edge. A non-owning line going low has no effect. The data words keep their last value.
- R7: A one-cycle pulse on clr_i while busy clears busy and irq_o on the next edge.
- R8: When several lines rise in the same cycle while idle, the lowest-numbered source is delivered.
- R9: Legacy lines map to vectors as follows: line 1 to 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22, line 12 to 0x2A.
- R10: Legacy lines 0, 2, 3, 5, 8 to 11 and 13 to 15 never cause a delivery.
- R11: A line that is still high after a clear by clr_i is not delivered again until it goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_i | input | 64 | Vector source lines, level sensitive |
| leg_i | input | 16 | Legacy bus interrupt lines |
| clr_i | input | 1 | Core-side clear of the outstanding delivery |
| status_o | output | 8 | Status; bit 5 is the busy flag |
| irq_o | output | 1 | Interrupt request to the core |
| trap_o | output | 9 | Trap type of the pending request |
| data0_o | output | 64 | Data word 0: tag and source number |
| data1_o | output | 64 | Data word 1 (zero) |
| data2_o | output | 64 | Data word 2 (zero) |

## Verification
The bench raises a second source while one delivery is outstanding. A design that queued or overwrote that source would show a changed data0_o, or a second delivery once the first one ends. It lowers a non-owning line while busy to catch a unit that ends the delivery on any falling edge. It holds a line high across a clr_i pulse to catch a unit that tests levels instead of edges. It raises several sources at once to catch priority inverted toward high indices. Each of the five legacy mappings is checked against its vector number, and the unmapped lines are driven to catch spurious translations.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int unsigned TRAP_W   = 9;
  localparam logic [TRAP_W-1:0] TRAP_IVEC = 9'h060;
  localparam logic [4:0]  DATA_TAG = 5'h1f;
  localparam int unsigned TAG_LSB  = 6;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BUSY_BIT = 5;

  // {valid, vector} for a legacy line
  function automatic logic [6:0] leg_map(input int line);
    case (line)
      1:       return {1'b1, 6'h29};
      4:       return {1'b1, 6'h2b};
      6:       return {1'b1, 6'h27};
      7:       return {1'b1, 6'h22};
      12:      return {1'b1, 6'h2a};
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/ivec_legacy_map.sv
module ivec_legacy_map #(
  parameter int unsigned N_LEG = 16,
  parameter int unsigned N_VEC = 64
) (
  input  logic [N_LEG-1:0] leg_i,
  output logic [N_VEC-1:0] hit_o
);
  import ivec_pkg::*;

  for (genvar j = 0; j < N_VEC; j++) begin : g_tgt
    logic hit_j;
    always_comb begin
      logic [6:0] m;
      hit_j = 1'b0;
      for (int i = 0; i < N_LEG; i++) begin
        m = leg_map(i);
        if (m[6] && (int'(m[5:0]) == j) && leg_i[i]) hit_j = 1'b1;
      end
    end
    assign hit_o[j] = hit_j;
  end
endmodule

// File: rtl/ivec_edge_pick.sv
module ivec_edge_pick #(
  parameter int unsigned N  = 64,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  lvl_i,
  output logic          fire_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] lvl_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise = lvl_i & ~lvl_q;

  // lowest index wins
  always_comb begin
    fire_o = 1'b0;
    idx_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rise[i]) begin
        fire_o = 1'b1;
        idx_o  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ivec_dispatch.sv
module ivec_dispatch
  import ivec_pkg::*;
#(
  parameter int unsigned N_VEC  = 64,
  parameter int unsigned N_LEG  = 16,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IW = (N_VEC > 1) ? $clog2(N_VEC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_VEC-1:0]  vec_i,
  input  logic [N_LEG-1:0]  leg_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic [TRAP_W-1:0] trap_o,
  output logic [DATA_W-1:0] data0_o,
  output logic [DATA_W-1:0] data1_o,
  output logic [DATA_W-1:0] data2_o
);
  logic [N_VEC-1:0]  leg_hit;
  logic [N_VEC-1:0]  eff;
  logic              fire;
  logic [IW-1:0]     idx;
  logic              busy_q;
  logic [IW-1:0]     src_q;
  logic [DATA_W-1:0] data0_q, data1_q, data2_q;
  logic [DATA_W-1:0] data0_d;
  logic              drop;

  ivec_legacy_map #(.N_LEG(N_LEG), .N_VEC(N_VEC)) u_map (
    .leg_i (leg_i),
    .hit_o (leg_hit)
  );

  assign eff = vec_i | leg_hit;

  ivec_edge_pick #(.N(N_VEC)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (eff),
    .fire_o (fire),
    .idx_o  (idx)
  );

  // owner dropped its line, or core cleared
  assign drop = busy_q && (clr_i || !eff[src_q]);

  always_comb begin
    data0_d = '0;
    data0_d[TAG_LSB +: 5] = DATA_TAG;
    data0_d[IW-1:0]       = idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      src_q   <= '0;
      data0_q <= '0;
      data1_q <= '0;
      data2_q <= '0;
    end else if (busy_q) begin
      if (drop) busy_q <= 1'b0;
    end else if (fire) begin
      busy_q  <= 1'b1;
      src_q   <= idx;
      data0_q <= data0_d;
      data1_q <= '0;
      data2_q <= '0;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[BUSY_BIT] = busy_q;
  end
  assign irq_o   = busy_q;
  assign trap_o  = busy_q ? TRAP_IVEC : '0;
  assign data0_o = data0_q;
  assign data1_o = data1_q;
  assign data2_o = data2_q;

  // R2
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && fire) |=> busy_q);

  // R3
  data_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (data0_q[TAG_LSB +: 5] == DATA_TAG && data1_q == '0 && data2_q == '0));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !drop) |=> (busy_q && $stable(src_q) && $stable(data0_q)));

  // R6
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> !busy_q);

  // R4
  trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (trap_o == '0));
endmodule

// File: tb/ivec_dispatch_bench.sv
module ivec_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] vec = '0;
  logic [15:0] leg = '0;
  logic        clr = 1'b0;
  logic [7:0]  status;
  logic        irq;
  logic [8:0]  trap;
  logic [63:0] d0, d1, d2;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ivec_dispatch u_ivec_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .vec_i(vec), .leg_i(leg), .clr_i(clr),
    .status_o(status), .irq_o(irq), .trap_o(trap),
    .data0_o(d0), .data1_o(d1), .data2_o(d2)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [63:0] word0(input int src);
    return (64'h1f << 6) | 64'(src);
  endfunction

  task automatic expect_idle(input string req);
    chk({req, " status"}, 64'(status), 64'h0);
    chk({req, " irq"}, 64'(irq), 64'h0);
    chk({req, " trap"}, 64'(trap), 64'h0);
  endtask

  task automatic expect_busy(input string req, input int src);
    chk({req, " status"}, 64'(status), 64'h20);
    chk({req, " irq"}, 64'(irq), 64'h1);
    chk({req, " trap"}, 64'(trap), 64'h060);
    chk({req, " data0"}, d0, word0(src));
    chk({req, " data1"}, d1, 64'h0);
    chk({req, " data2"}, d2, 64'h0);
  endtask

  task automatic t_reset();
    expect_idle("R1");
    chk("R1 data0", d0, 64'h0);
    chk("R1 data1", d1, 64'h0);
    chk("R1 data2", d2, 64'h0);
  endtask

  task automatic t_single();
    vec[5] = 1'b1; step();
    expect_busy("R2 R3 R4 src5", 5);
    chk("R3 value", d0, 64'h7c5);
    vec[5] = 1'b0; step();
    expect_idle("R6 R4 owner low");
    chk("R6 data kept", d0, 64'h7c5);
    vec[63] = 1'b1; step();
    expect_busy("R3 src63", 63);
    chk("R3 top value", d0, 64'h7ff);
    vec[63] = 1'b0; step();
    vec[0] = 1'b1; step();
    expect_busy("R3 src0", 0);
    vec[0] = 1'b0; step();
    expect_idle("R6 src0 low");
  endtask

  task automatic t_busy_ignore();
    vec[10] = 1'b1; step();
    expect_busy("R5 owner", 10);
    vec[3] = 1'b1; step();
    expect_busy("R5 second rise ignored", 10);
    vec[3] = 1'b0; step();
    expect_busy("R6 non-owner low", 10);
    vec[3] = 1'b1; step();
    vec[10] = 1'b0; step();
    expect_idle("R5 owner low");
    step();
    expect_idle("R5 no replay");
    vec[3] = 1'b0; step();
    expect_idle("R5 cleanup");
  endtask

  task automatic t_clear();
    vec[20] = 1'b1; step();
    expect_busy("R7 deliver", 20);
    clr = 1'b1; step();
    clr = 1'b0;
    expect_idle("R7 clear");
    step(); step();
    expect_idle("R11 held high");
    vec[20] = 1'b0; step();
    vec[20] = 1'b1; step();
    expect_busy("R11 re-rise", 20);
    vec[20] = 1'b0; step();
    expect_idle("R11 end");
  endtask

  task automatic t_simul();
    vec[40] = 1'b1; vec[17] = 1'b1; vec[33] = 1'b1; step();
    expect_busy("R8 lowest wins", 17);
    vec[40] = 1'b0; vec[17] = 1'b0; vec[33] = 1'b0; step();
    expect_idle("R8 end");
  endtask

  function automatic int leg_exp(input int line);
    case (line)
      1: return 'h29; 4: return 'h2b; 6: return 'h27;
      7: return 'h22; 12: return 'h2a;
      default: return -1;
    endcase
  endfunction

  task automatic t_legacy();
    for (int l = 0; l < 16; l++) begin
      leg[l] = 1'b1; step();
      if (leg_exp(l) >= 0) begin
        expect_busy($sformatf("R9 line %0d", l), leg_exp(l));
      end else begin
        chk($sformatf("R10 line %0d irq", l), 64'(irq), 64'h0);
        step();
        chk($sformatf("R10 line %0d status", l), 64'(status), 64'h0);
      end
      leg[l] = 1'b0; step();
      expect_idle($sformatf("R9 line %0d end", l));
    end
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_busy_ignore();
    t_clear();
    t_simul();
    t_legacy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule